// File: doc/BRIEF.md
# Grouped Edge-Latched Interrupt Vector Controller

This block gathers a large set of interrupt vectors and reports them to a parent interrupt controller. The vectors are split into groups of 32. A rising edge on any vector input sets a pending bit in the status word of its group. Each group also has an enable word. A group raises its own output line while at least one of its pending vectors is enabled.

Software uses a small 32-bit register bus. It reads a group's status word to find pending vectors and clears them by writing ones (write-one-to-clear). It masks or unmasks single vectors by read-modify-write of the enable word. Vector n belongs to group n/32, at bit n%32. The number of groups is a parameter from 1 to 8. The register slots of groups that are not built read as zero.

Top module: `vecgrp_irq_ctrl`

## Requirements
- R1: After a synchronous reset every status bit, every enable bit, every output line and the read data are zero.
- R2: A rising edge on vector input n sets bit n%32 of status word n/32 whatever the enable bit holds. An input held high sets the bit only once, on its rising edge, and is not seen again after the bit is cleared.
- R3: The status word of group i is at byte address 4*i. A write there clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing 0xFFFFFFFF clears the whole group.
- R4: The enable word of group i is at byte address 0x20 + 4*i and is read/write. A bit value of 1 enables the vector.
- R5: Output line i is high one clock cycle after (status_i & enable_i) becomes non-zero. It goes low one cycle after that value becomes zero, for example through masking or clearing. Each group drives only its own line.
- R6: When a rising edge and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R7: Byte addresses 0x40 and above, and the status and enable slots of groups at or above the configured group count, read as zero. Writes to them change no register and no output line.
- R8: Read data is registered. It shows the addressed word on the cycle after the read strobe is sampled, and it holds that value until the next read.
- R9: A second edge on a vector that is still pending is absorbed. After the vector is acknowledged, a new edge sets it again.
- R10: The two low address bits are ignored, so accesses are word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_in | input | NUM_GROUPS*32 | Vector inputs, synchronous to clk; bit n is vector n |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, sampled on the rising clock edge |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_GROUPS | One interrupt line per group toward the parent |

## Verification
The assertions assume the vector inputs are already synchronous to the clock. They also assume read and write strobes are never raised in the same cycle. The bench changes every input on the falling clock edge and issues each bus access as a single strobe, so both assumptions hold. The vector inputs stay low through reset, so no edge is seen when reset is released. The same-cycle edge and clear case is created on purpose by raising a vector and a status write together.

// File: rtl/vecgrp_pkg.sv
package vecgrp_pkg;
  localparam int VEC_PER_GRP   = 32;
  localparam int MAX_GROUPS    = 8;
  localparam int ENABLE_WORD0  = 8;   // enable slots start at byte 0x20
  localparam int MAPPED_WORDS  = 16;  // byte 0x00 .. 0x3C

  typedef logic [VEC_PER_GRP-1:0] grp_word_t;
endpackage

// File: rtl/vecgrp_edge_det.sv
module vecgrp_edge_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sig_in;
  end

  assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/vecgrp_group.sv
module vecgrp_group
  import vecgrp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  grp_word_t rise,
  input  logic      stat_wr,
  input  logic      en_wr,
  input  grp_word_t wdata,
  output grp_word_t status_q,
  output grp_word_t enable_q,
  output logic      irq_q
);
  grp_word_t status_nxt;

  always_comb begin
    status_nxt = status_q;
    if (stat_wr) status_nxt = status_nxt & ~wdata;
    status_nxt = status_nxt | rise;     // new edge wins over a clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_nxt;
      if (en_wr) enable_q <= wdata;
      irq_q    <= |(status_q & enable_q);
    end
  end

  // an edge always leaves its bit set
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((status_q & $past(rise)) == $past(rise)));

  // written ones are cleared unless an edge collides
  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && rise == '0) |=> ((status_q & $past(wdata)) == '0));

  // pending bits never vanish without a status write
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!stat_wr) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // fully masked group keeps its line low next cycle
  p_masked_low_r5: assert property (@(posedge clk) disable iff (rst)
    (enable_q == '0) |=> !irq_q);

  // collision resolves to set
  p_collide_set_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && (rise & wdata) != '0) |=> ((status_q & $past(rise & wdata)) != '0));
endmodule

// File: rtl/vecgrp_bus_decode.sv
module vecgrp_bus_decode
  import vecgrp_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8
) (
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_wr,
  input  logic [NUM_GROUPS*VEC_PER_GRP-1:0] status_flat,
  input  logic [NUM_GROUPS*VEC_PER_GRP-1:0] enable_flat,
  output logic [NUM_GROUPS-1:0]             stat_wr_sel,
  output logic [NUM_GROUPS-1:0]             en_wr_sel,
  output grp_word_t                         rd_mux
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  assign widx = bus_addr[ADDR_W-1:2];

  always_comb begin
    stat_wr_sel = '0;
    en_wr_sel   = '0;
    rd_mux      = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (int'(widx) == g) begin
        stat_wr_sel[g] = bus_wr;
        rd_mux         = status_flat[g*VEC_PER_GRP +: VEC_PER_GRP];
      end
      if (int'(widx) == ENABLE_WORD0 + g) begin
        en_wr_sel[g] = bus_wr;
        rd_mux       = enable_flat[g*VEC_PER_GRP +: VEC_PER_GRP];
      end
    end
  end
endmodule

// File: rtl/vecgrp_irq_ctrl.sv
module vecgrp_irq_ctrl
  import vecgrp_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_GROUPS*VEC_PER_GRP-1:0] vec_in,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_wr,
  input  logic [VEC_PER_GRP-1:0]            bus_wdata,
  input  logic                              bus_rd,
  output logic [VEC_PER_GRP-1:0]            bus_rdata,
  output logic [NUM_GROUPS-1:0]             irq_out
);
  localparam int NVEC = NUM_GROUPS * VEC_PER_GRP;

  logic [NVEC-1:0]       rise;
  logic [NVEC-1:0]       status_flat;
  logic [NVEC-1:0]       enable_flat;
  logic [NUM_GROUPS-1:0] stat_wr_sel;
  logic [NUM_GROUPS-1:0] en_wr_sel;
  grp_word_t             rd_mux;

  vecgrp_edge_det #(.W(NVEC)) u_edge (
    .clk(clk), .rst(rst), .sig_in(vec_in), .rise(rise)
  );

  vecgrp_bus_decode #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr),
    .status_flat(status_flat), .enable_flat(enable_flat),
    .stat_wr_sel(stat_wr_sel), .en_wr_sel(en_wr_sel), .rd_mux(rd_mux)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    vecgrp_group u_grp (
      .clk     (clk),
      .rst     (rst),
      .rise    (rise[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .stat_wr (stat_wr_sel[g]),
      .en_wr   (en_wr_sel[g]),
      .wdata   (bus_wdata),
      .status_q(status_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .enable_q(enable_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .irq_q   (irq_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // reset clears every output line
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && bus_rdata == '0));

  // reads beyond the mapped window return zero
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr[ADDR_W-1:2]) >= MAPPED_WORDS) |=> (bus_rdata == '0));

  // writes beyond the mapped window select no group
  p_unmapped_nowr_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(bus_addr[ADDR_W-1:2]) >= MAPPED_WORDS) |-> (stat_wr_sel == '0 && en_wr_sel == '0));

  // read data holds between reads
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // the write select never touches more than one register
  p_one_target_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stat_wr_sel, en_wr_sel}));
endmodule

// File: tb/vecgrp_irq_ctrl_bench.sv
module vecgrp_irq_ctrl_bench;
  localparam int NG   = 6;
  localparam int AW   = 8;
  localparam int NVEC = NG * 32;

  logic            clk = 1'b0;
  logic            rst;
  logic [NVEC-1:0] vec_in;
  logic [AW-1:0]   bus_addr;
  logic            bus_wr;
  logic [31:0]     bus_wdata;
  logic            bus_rd;
  logic [31:0]     bus_rdata;
  logic [NG-1:0]   irq_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  vecgrp_irq_ctrl #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_vecgrp_irq_ctrl (
    .clk(clk), .rst(rst), .vec_in(vec_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    vec_in[n] = 1'b1;
    @(negedge clk);
    vec_in[n] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq_out", 32'(irq_out), 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    bus_read(8'h00, d); check("R1 status0", d, 32'h0);
    bus_read(8'h34, d); check("R1 enable5", d, 32'h0);
  endtask

  task automatic t_edge_masked;
    logic [31:0] d;
    pulse(37);
    bus_read(8'h04, d); check("R2 status1 bit5", d, 32'h20);
    check("R5 masked line low", 32'(irq_out), 32'h0);
    @(negedge clk); vec_in[64] = 1'b1;
    repeat (3) @(negedge clk);
    bus_write(8'h08, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    bus_read(8'h08, d); check("R2 held high not re-seen", d, 32'h0);
    vec_in[64] = 1'b0;
    bus_write(8'h04, 32'h20);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    pulse(37);
    bus_write(8'h24, 32'h20);
    bus_read(8'h24, d); check("R4 enable1 readback", d, 32'h20);
    check("R5 line1 high", 32'(irq_out), 32'h2);
    bus_write(8'h24, 32'h0);
    @(negedge clk);
    check("R5 line1 low after mask", 32'(irq_out), 32'h0);
    bus_write(8'h24, 32'h20);
    @(negedge clk);
    bus_write(8'h04, 32'h20);
    @(negedge clk);
    check("R5 line1 low after clear", 32'(irq_out), 32'h0);
    bus_write(8'h24, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    @(negedge clk); vec_in[2:0] = 3'b111;
    @(negedge clk); vec_in[2:0] = 3'b000;
    bus_write(8'h00, 32'h2);
    bus_read(8'h00, d); check("R3 clear one bit", d, 32'h5);
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, d); check("R3 zero write keeps", d, 32'h5);
    bus_write(8'h03, 32'hFFFF_FFFF);
    bus_read(8'h01, d); check("R10 low bits ignored", d, 32'h0);
  endtask

  task automatic t_collide_rearm;
    logic [31:0] d;
    @(negedge clk);
    vec_in[3] = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h8; bus_wr = 1'b1;
    @(negedge clk);
    vec_in[3] = 1'b0; bus_wr = 1'b0;
    bus_read(8'h00, d); check("R6 edge wins", d, 32'h8);
    pulse(3);
    bus_read(8'h00, d); check("R9 second edge absorbed", d, 32'h8);
    bus_write(8'h00, 32'h8);
    bus_read(8'h00, d); check("R9 acked", d, 32'h0);
    pulse(3);
    bus_read(8'h00, d); check("R9 rearmed", d, 32'h8);
    bus_write(8'h00, 32'h8);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_read(8'h40, d); check("R7 above window", d, 32'h0);
    bus_write(8'h38, 32'hFFFF_FFFF);
    bus_read(8'h38, d); check("R7 unbuilt enable", d, 32'h0);
    bus_read(8'h18, d); check("R7 unbuilt status", d, 32'h0);
    bus_read(8'h20, d); check("R7 enable0 untouched", d, 32'h0);
    check("R7 lines untouched", 32'(irq_out), 32'h0);
  endtask

  task automatic t_rd_latency;
    logic [31:0] d;
    bus_write(8'h2C, 32'hA5A5_0001);
    bus_read(8'h2C, d); check("R8 value after strobe", d, 32'hA5A5_0001);
    @(negedge clk);
    bus_addr = 8'h20; bus_rd = 1'b1;
    #1 check("R8 registered not combinational", bus_rdata, 32'hA5A5_0001);
    @(negedge clk); bus_rd = 1'b0;
    check("R8 new value", bus_rdata, 32'h0);
    bus_write(8'h2C, 32'h0);
    @(negedge clk);
    check("R8 holds between reads", bus_rdata, 32'h0);
  endtask

  task automatic t_multi_group;
    bus_write(8'h28, 32'h8000_0000);
    bus_write(8'h34, 32'h1);
    @(negedge clk);
    vec_in[2*32+31] = 1'b1; vec_in[5*32] = 1'b1;
    @(negedge clk);
    vec_in[2*32+31] = 1'b0; vec_in[5*32] = 1'b0;
    @(negedge clk);
    check("R5 lines 2 and 5", 32'(irq_out), 32'h24);
    bus_write(8'h08, 32'h8000_0000);
    @(negedge clk);
    check("R5 only line 5", 32'(irq_out), 32'h20);
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; vec_in = '0; bus_addr = '0; bus_wr = 1'b0;
    bus_wdata = '0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_edge_masked();
    t_enable();
    t_w1c();
    t_collide_rearm();
    t_unmapped();
    t_rd_latency();
    t_multi_group();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule